// File: doc/BRIEF.md
# GPIO and Control Register File

This block is a 16-bit peripheral register file that sits on a simple synchronous register bus. The bus has an address, a read strobe, a write strobe, write data and registered read data. The file holds these registers:

- a mode register
- a clock-divider register
- a fixed status word
- a power register with a write side effect
- a clock-control register
- three interrupt-related registers: raw, mask and status

It also holds a 16-line GPIO port, which has a direction mask and a level register. Each GPIO output is its level bit gated by its direction bit. Each line also has an external input that can set or clear its level bit.

Every bus access completes in the cycle its strobe is high, and the bus never stalls. The interface is therefore plain strobes, with no valid/ready handshake and no back-pressure. Read data and the bad-access flag are both registered, and they appear together one cycle after the strobe. A host decodes the low six address bits, so the register set repeats every 0x40 bytes. A stray access, such as an unmapped offset or a write to the status word, is reported on the bad-access flag.

Top module: `gpctl_regfile`

## Requirements
- R1: After reset every register reads 0 except the status word at offset 0x08, which reads 0x0002. `gpio_out` and `bad_access` are 0.
- R2: The read data of a read strobed in cycle k appears on `bus_rdata` in cycle k+1.
- R3: Offsets 0x00 (mode), 0x04 (clock divider), 0x10 (clock control), 0x14 (raw interrupt), 0x18 (interrupt mask) and 0x1C (interrupt status) read back the last value written. Stored values are the low 16 bits of `bus_wdata`.
- R4: A write to the power register at 0x0C stores the written value. If bit 7 of that value is 1, bits 15 and 6 (mask 0x8040) are also set.
- R5: The status word at 0x08 is read-only. A write to it leaves it at 0x0002 and raises `bad_access`.
- R6: Offset 0x20 reads and writes the direction mask. A write to 0x24 or 0x28 stores the written value ANDed with the direction mask into the level register. A read of either 0x24 or 0x28 returns the level register.
- R7: `gpio_out[n]` equals level[n] AND dir[n], and it follows a write to either register from the next cycle on.
- R8: When `ext_we[n]` is 1, level[n] takes `ext_val[n]` on the next edge, without masking by direction.
- R9: When a bus write to the level register and an external update fall in the same cycle, the bus write decides every level bit.
- R10: Any access to an offset other than the eleven listed is unmapped. Such an access reads 0 and raises `bad_access` in the cycle after the strobe. `bad_access` is 0 after a cycle with no strobe.
- R11: Only address bits [5:0] are decoded, so an address plus any multiple of 0x40 reaches the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address; bits [5:0] decoded |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | WDATA_W | Write data; low 16 bits kept |
| bus_rdata | output | 16 | Registered read data |
| bad_access | output | 1 | Registered flag for a stray access |
| ext_we | input | NLINES | Per-line external level update enable |
| ext_val | input | NLINES | Per-line external level value |
| gpio_out | output | NLINES | Level gated by direction |

## Verification
The bench builds the block with its defaults: a 12-bit address, 32-bit write data and 16 lines. The 12-bit address puts the aliases at 0x44, 0x5C and 0x90 within reach of the decode. The 32-bit write data lets a value with nonzero upper bits show that only the low half is stored. With 16 lines, an external update to line 8 can land on a line whose direction bit is clear, so the unmasked level shows up in the readback but not on `gpio_out`.

// File: rtl/gpctl_pkg.sv
package gpctl_pkg;

  // Decoded offsets (low six address bits). A neighbour's driver depends on these.
  localparam logic [5:0] OFS_MODE   = 6'h00;
  localparam logic [5:0] OFS_CLKDIV = 6'h04;
  localparam logic [5:0] OFS_STAT   = 6'h08;
  localparam logic [5:0] OFS_PWR    = 6'h0C;
  localparam logic [5:0] OFS_CLKCTL = 6'h10;
  localparam logic [5:0] OFS_IRQRAW = 6'h14;
  localparam logic [5:0] OFS_IRQMSK = 6'h18;
  localparam logic [5:0] OFS_IRQSTS = 6'h1C;
  localparam logic [5:0] OFS_DIR    = 6'h20;
  localparam logic [5:0] OFS_LVLW   = 6'h24;
  localparam logic [5:0] OFS_LVLR   = 6'h28;

  localparam logic [15:0] STAT_RESET = 16'h0002;
  localparam logic [15:0] PWR_FORCE  = 16'h8040;
  localparam int unsigned PWR_TRIG   = 7;

  typedef enum logic [3:0] {
    SEL_MODE, SEL_CLKDIV, SEL_STAT, SEL_PWR, SEL_CLKCTL,
    SEL_IRQRAW, SEL_IRQMSK, SEL_IRQSTS, SEL_DIR, SEL_LVLW,
    SEL_LVLR, SEL_NONE
  } reg_sel_e;

  // Plain storage registers held in the control bank
  localparam int unsigned NPLAIN     = 6;
  localparam int unsigned IDX_MODE   = 0;
  localparam int unsigned IDX_CLKDIV = 1;
  localparam int unsigned IDX_CLKCTL = 2;
  localparam int unsigned IDX_IRQRAW = 3;
  localparam int unsigned IDX_IRQMSK = 4;
  localparam int unsigned IDX_IRQSTS = 5;

endpackage

// File: rtl/gpctl_decode.sv
module gpctl_decode
  import gpctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              hit
);

  localparam int unsigned DEC_W = 6;

  logic [ADDR_W-1:0] unused_addr;
  assign unused_addr = addr;

  // Only the low six bits take part (R11)
  always_comb begin
    case (addr[DEC_W-1:0])
      OFS_MODE:   sel = SEL_MODE;
      OFS_CLKDIV: sel = SEL_CLKDIV;
      OFS_STAT:   sel = SEL_STAT;
      OFS_PWR:    sel = SEL_PWR;
      OFS_CLKCTL: sel = SEL_CLKCTL;
      OFS_IRQRAW: sel = SEL_IRQRAW;
      OFS_IRQMSK: sel = SEL_IRQMSK;
      OFS_IRQSTS: sel = SEL_IRQSTS;
      OFS_DIR:    sel = SEL_DIR;
      OFS_LVLW:   sel = SEL_LVLW;
      OFS_LVLR:   sel = SEL_LVLR;
      default:    sel = SEL_NONE;
    endcase
  end

  assign hit = (sel != SEL_NONE);

  // Nothing above the last mapped offset decodes to a register
  always_comb begin
    AST_NO_HIT_ABOVE_MAP: assert (!(addr[DEC_W-1:0] > OFS_LVLR) || !hit); // R10
  end

endmodule

// File: rtl/gpctl_ctrl_bank.sv
module gpctl_ctrl_bank
  import gpctl_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  reg_sel_e                     sel,
  input  logic [REG_W-1:0]             wdata,
  output logic [NPLAIN-1:0][REG_W-1:0] plain_q,
  output logic [REG_W-1:0]             pwr_q
);

  localparam reg_sel_e PLAIN_SEL [NPLAIN] = '{
    SEL_MODE, SEL_CLKDIV, SEL_CLKCTL, SEL_IRQRAW, SEL_IRQMSK, SEL_IRQSTS
  };
  localparam logic [REG_W-1:0] FORCE_MASK = REG_W'(PWR_FORCE);

  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                             q <= '0;
      else if (wr_en && sel == PLAIN_SEL[i])  q <= wdata;
    end
    assign plain_q[i] = q;
  end

  logic pwr_we;
  assign pwr_we = wr_en && (sel == SEL_PWR);

  always_ff @(posedge clk) begin
    if (!rst_n)      pwr_q <= '0;
    else if (pwr_we) pwr_q <= wdata[PWR_TRIG] ? (wdata | FORCE_MASK) : wdata;
  end

  AST_PWR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_we && wdata[PWR_TRIG]) |=> ((pwr_q & FORCE_MASK) == FORCE_MASK)); // R4
  AST_PWR_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_we && !wdata[PWR_TRIG]) |=> (pwr_q == $past(wdata))); // R4

endmodule

// File: rtl/gpctl_gpio.sv
module gpctl_gpio #(
  parameter int unsigned NLINES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_wr,
  input  logic              lvl_wr,
  input  logic [NLINES-1:0] wdata,
  input  logic [NLINES-1:0] ext_we,
  input  logic [NLINES-1:0] ext_val,
  output logic [NLINES-1:0] dir_q,
  output logic [NLINES-1:0] lvl_q,
  output logic [NLINES-1:0] gpio_out
);

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= wdata;
  end

  // Per line: bus write (masked) wins over the external update
  for (genvar n = 0; n < NLINES; n++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)         lvl_q[n] <= 1'b0;
      else if (lvl_wr)    lvl_q[n] <= wdata[n] & dir_q[n];
      else if (ext_we[n]) lvl_q[n] <= ext_val[n];
    end
  end

  assign gpio_out = lvl_q & dir_q;

  AST_LVL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> ((lvl_q & ~$past(dir_q)) == '0)); // R6
  AST_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_wr && (ext_we != '0)) |=> (lvl_q == $past(wdata & dir_q))); // R9
  AST_EXT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_wr |=> (((lvl_q ^ $past(ext_val)) & $past(ext_we)) == '0)); // R8

endmodule

// File: rtl/gpctl_regfile.sv
module gpctl_regfile
  import gpctl_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned WDATA_W = 32,
  parameter int unsigned NLINES  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [WDATA_W-1:0] bus_wdata,
  output logic [15:0]        bus_rdata,
  output logic               bad_access,
  input  logic [NLINES-1:0]  ext_we,
  input  logic [NLINES-1:0]  ext_val,
  output logic [NLINES-1:0]  gpio_out
);

  localparam int unsigned REG_W = 16;

  reg_sel_e         sel;
  logic             hit;
  logic [REG_W-1:0] wd;
  logic [WDATA_W-1:0] unused_wdata;

  assign wd           = bus_wdata[REG_W-1:0];
  assign unused_wdata = bus_wdata;

  gpctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel),
    .hit  (hit)
  );

  logic [NPLAIN-1:0][REG_W-1:0] plain_q;
  logic [REG_W-1:0]             pwr_q;

  gpctl_ctrl_bank #(.REG_W(REG_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .sel     (sel),
    .wdata   (wd),
    .plain_q (plain_q),
    .pwr_q   (pwr_q)
  );

  logic              dir_wr, lvl_wr;
  logic [NLINES-1:0] dir_q, lvl_q;

  assign dir_wr = bus_wr && (sel == SEL_DIR);
  assign lvl_wr = bus_wr && (sel == SEL_LVLW || sel == SEL_LVLR);

  gpctl_gpio #(.NLINES(NLINES)) u_gpio (
    .clk      (clk),
    .rst_n    (rst_n),
    .dir_wr   (dir_wr),
    .lvl_wr   (lvl_wr),
    .wdata    (wd[NLINES-1:0]),
    .ext_we   (ext_we),
    .ext_val  (ext_val),
    .dir_q    (dir_q),
    .lvl_q    (lvl_q),
    .gpio_out (gpio_out)
  );

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_MODE:   rd_mux = plain_q[IDX_MODE];
      SEL_CLKDIV: rd_mux = plain_q[IDX_CLKDIV];
      SEL_STAT:   rd_mux = REG_W'(STAT_RESET);
      SEL_PWR:    rd_mux = pwr_q;
      SEL_CLKCTL: rd_mux = plain_q[IDX_CLKCTL];
      SEL_IRQRAW: rd_mux = plain_q[IDX_IRQRAW];
      SEL_IRQMSK: rd_mux = plain_q[IDX_IRQMSK];
      SEL_IRQSTS: rd_mux = plain_q[IDX_IRQSTS];
      SEL_DIR:    rd_mux = REG_W'(dir_q);
      SEL_LVLW,
      SEL_LVLR:   rd_mux = REG_W'(lvl_q);
      default:    rd_mux = '0;
    endcase
  end

  logic bad_now;
  assign bad_now = ((bus_rd || bus_wr) && !hit) || (bus_wr && sel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bad_access <= 1'b0;
    end else begin
      bus_rdata  <= bus_rd ? rd_mux : '0;
      bad_access <= bad_now;
    end
  end

  AST_QUIET_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd || bus_wr) |=> !bad_access); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !hit) |=> (bus_rdata == '0 && bad_access)); // R10
  AST_STAT_WR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_STAT) |=> bad_access); // R5

endmodule

// File: tb/sim_gpctl_regfile.sv
module sim_gpctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bad_access;
  logic [15:0] ext_we = '0, ext_val = '0;
  logic [15:0] gpio_out;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpctl_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bad_access(bad_access), .ext_we(ext_we), .ext_val(ext_val),
    .gpio_out(gpio_out)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic bad);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    bad = bad_access;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [15:0] d, output logic bad);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; bad = bad_access;
  endtask

  // {req[3:0], is_write, addr[11:0], wdata[31:0], expect[15:0], bad}
  localparam int NV = 27;
  localparam logic [65:0] VEC [NV] = '{
    {4'd3,  1'b1, 12'h000, 32'h0001_A5A5, 16'h0000, 1'b0}, // R3 upper half dropped
    {4'd3,  1'b0, 12'h000, 32'h0,         16'hA5A5, 1'b0},
    {4'd11, 1'b1, 12'h004, 32'h0000_1111, 16'h0000, 1'b0}, // R11
    {4'd11, 1'b0, 12'h044, 32'h0,         16'h1111, 1'b0},
    {4'd4,  1'b1, 12'h00C, 32'h0000_0081, 16'h0000, 1'b0}, // R4 force
    {4'd4,  1'b0, 12'h00C, 32'h0,         16'h80C1, 1'b0},
    {4'd4,  1'b1, 12'h00C, 32'h0000_0001, 16'h0000, 1'b0}, // R4 no force
    {4'd4,  1'b0, 12'h00C, 32'h0,         16'h0001, 1'b0},
    {4'd5,  1'b1, 12'h008, 32'h0000_FFFF, 16'h0000, 1'b1}, // R5
    {4'd5,  1'b0, 12'h008, 32'h0,         16'h0002, 1'b0},
    {4'd6,  1'b1, 12'h020, 32'h0000_00FF, 16'h0000, 1'b0}, // R6 dir
    {4'd6,  1'b1, 12'h024, 32'h0000_FFFF, 16'h0000, 1'b0},
    {4'd6,  1'b0, 12'h028, 32'h0,         16'h00FF, 1'b0},
    {4'd6,  1'b0, 12'h020, 32'h0,         16'h00FF, 1'b0},
    {4'd6,  1'b1, 12'h028, 32'h0000_0F0F, 16'h0000, 1'b0},
    {4'd6,  1'b0, 12'h024, 32'h0,         16'h000F, 1'b0},
    {4'd10, 1'b0, 12'h02C, 32'h0,         16'h0000, 1'b1}, // R10
    {4'd11, 1'b1, 12'h010, 32'h0000_BEEF, 16'h0000, 1'b0},
    {4'd11, 1'b0, 12'h090, 32'h0,         16'hBEEF, 1'b0},
    {4'd3,  1'b1, 12'h014, 32'hFFFF_1234, 16'h0000, 1'b0},
    {4'd3,  1'b0, 12'h014, 32'h0,         16'h1234, 1'b0},
    {4'd3,  1'b1, 12'h018, 32'h0000_5678, 16'h0000, 1'b0},
    {4'd3,  1'b0, 12'h018, 32'h0,         16'h5678, 1'b0},
    {4'd11, 1'b1, 12'h01C, 32'h0000_9ABC, 16'h0000, 1'b0},
    {4'd11, 1'b0, 12'h05C, 32'h0,         16'h9ABC, 1'b0},
    {4'd10, 1'b0, 12'h001, 32'h0,         16'h0000, 1'b1},
    {4'd10, 1'b1, 12'h03C, 32'h0000_7777, 16'h0000, 1'b1}
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [65:0] v;
    logic [15:0] rd;
    logic        bd;
    string       tag;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 gpio_out", gpio_out, 16'h0);
    chk("R1 bad_access", {15'h0, bad_access}, 16'h0);
    do_read(12'h008, rd, bd); chk("R1 status", rd, 16'h0002);
    do_read(12'h000, rd, bd); chk("R1 mode", rd, 16'h0000);
    do_read(12'h020, rd, bd); chk("R1 dir", rd, 16'h0000);

    // R2 latency: data appears exactly one cycle after the strobe, gone the next
    @(negedge clk); bus_addr = 12'h008; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    chk("R2 data at k+1", bus_rdata, 16'h0002);
    @(negedge clk);
    chk("R2 no data without strobe", bus_rdata, 16'h0000);
    chk("R10 no flag when idle", {15'h0, bad_access}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      tag = $sformatf("R%0d row %0d", v[65:62], i);
      if (v[61]) begin
        do_write(v[60:49], v[48:17], bd);
      end else begin
        do_read(v[60:49], rd, bd);
        chk({tag, " data"}, rd, v[16:1]);
      end
      chk({tag, " bad"}, {15'h0, bd}, {15'h0, v[0]});
    end

    // R7: dir 0x00FF, level 0x000F
    chk("R7 out", gpio_out, 16'h000F);
    do_write(12'h020, 32'h0000_0003, bd);
    chk("R7 out after dir write", gpio_out, 16'h0003);

    // R8: external set on a line whose direction bit is clear
    @(negedge clk); ext_we = 16'h0100; ext_val = 16'h0100;
    @(negedge clk); ext_we = 16'h0;
    chk("R8 out unaffected", gpio_out, 16'h0003);
    do_read(12'h028, rd, bd); chk("R8 unmasked set", rd, 16'h010F);
    @(negedge clk); ext_we = 16'h0001; ext_val = 16'h0;
    @(negedge clk); ext_we = 16'h0;
    chk("R8 clear out", gpio_out, 16'h0002);
    do_read(12'h024, rd, bd); chk("R8 clear level", rd, 16'h010E);

    // R9: same-cycle bus write and external update
    @(negedge clk);
    bus_addr = 12'h024; bus_wdata = 32'h0000_FFFF; bus_wr = 1'b1;
    ext_we = 16'h8100; ext_val = 16'h8000;
    @(negedge clk); bus_wr = 1'b0; ext_we = 16'h0; ext_val = 16'h0;
    do_read(12'h024, rd, bd); chk("R9 bus wins", rd, 16'h0003);
    chk("R9 out", gpio_out, 16'h0003);

    // R1 again: reset mid-run clears written registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 out after reset", gpio_out, 16'h0);
    do_read(12'h00C, rd, bd); chk("R1 power after reset", rd, 16'h0000);
    do_read(12'h010, rd, bd); chk("R1 clkctl after reset", rd, 16'h0000);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule